// File: doc/BRIEF.md
# Paged Segment Address Translator

This block turns a two-part virtual address, a segment number and a word offset, into a physical word address. Segments and the descriptor table that lists them are both divided into fixed-size pages. The translator holds no tables of its own. Two inputs act as a base register: one gives the physical address of the page table that maps the descriptor table, and the other gives the highest segment number that may be used. The translator reads the tables it needs through a single read port with a valid/ready handshake.

A request carries the segment number, the offset, an access kind (read, write or execute) and the protection ring of the code that issues it. Ring 0 is the most privileged of 8 rings. The translator walks the tables in a fixed order. First it reads the page-table entry that locates the descriptor page. Next it reads the segment's descriptor word. Last it reads the segment's page-table entry. Before the last read it applies the descriptor's flag, length, ring and permission checks. The walk ends with a one-cycle `done` pulse. With it comes either a physical address or a 3-bit fault code, and the segment and offset of the request are echoed so that a fault handler can use them.

The walk is a five-state machine. IDLE waits for a request. RD_DPT reads the descriptor-page entry. RD_SDW reads the descriptor word. RD_SPT reads the segment page entry. FINISH pulses `done`. The transitions are:
- ACCEPT goes from IDLE to RD_DPT.
- EARLY_OUT goes from IDLE to FINISH when the segment number is out of range.
- DPT_MISS goes from RD_DPT to FINISH when the descriptor page is absent.
- DPT_HIT goes from RD_DPT to RD_SDW.
- SDW_BAD goes from RD_SDW to FINISH when a descriptor check fails.
- SDW_OK goes from RD_SDW to RD_SPT.
- SPT_DONE goes from RD_SPT to FINISH.
- RETIRE goes from FINISH to IDLE.

The machine leaves RD_DPT, RD_SDW and RD_SPT only in a cycle where a read is accepted.

Top module: `pst_translator`

## Requirements
- R1: A request whose segment number is greater than `dbr_len` completes with fault code 1 in the cycle after it is accepted, and the translator issues no memory read for it.
- R2: Let the page size be 2^PG_BITS words. The segment number splits into a high part sp and a low part sw (the low PG_BITS bits), and the offset splits into ip and iw in the same way. The reads are issued in this order: first `dbr_pt + sp`, then `{frame1, sw}`, then `pt_base + ip`. Here frame1 is the frame field of the first read and pt_base is taken from the descriptor word.
- R3: A page-table entry has its present flag in bit DW-1 and its frame number in bits [PA_W-PG_BITS-1:0]. If the descriptor-page entry is not present, the request completes with fault code 2 after exactly one read.
- R4: The descriptor word holds these fields: page-table base in [PA_W-1:0], length in the next OFF_W bits, ring in the next 3 bits, then single bits for read, write, execute and the fault flag, in that order. If the fault flag is set, the request completes with fault code 3.
- R5: An offset greater than the descriptor's length field completes with fault code 4.
- R6: A request whose ring is numerically greater than the descriptor's ring completes with fault code 6.
- R7: Access kind 0 (read) needs the read bit, kind 1 (write) needs the write bit and kind 2 (execute) needs the execute bit. Kind 3 is always refused. A refused request completes with fault code 5.
- R8: The descriptor checks apply in this priority: fault flag, then offset, then ring, then permission. Any of these faults ends the walk after exactly two reads.
- R9: If the segment page entry is not present, the request completes with fault code 7 after three reads. `res_seg` and `res_off` then show the request's segment and offset.
- R10: A translation with no fault completes with code 0 and `res_pa = {frame3, iw}`, where frame3 is the frame field of the third read.
- R11: `mem_valid` is raised only while the translator is busy. Once raised, it and `mem_addr` hold steady until `mem_ready` accepts the read.
- R12: After reset, `done`, `busy` and `mem_valid` are low and `res_code` is 0. `done` lasts one cycle. The results hold until the next request is accepted. A `req_valid` raised while the translator is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbr_pt | input | PA_W | Physical address of the descriptor table's page table |
| dbr_len | input | SEG_W | Highest permitted segment number |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Word offset within the segment |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_ring | input | 3 | Ring of the requesting code |
| busy | output | 1 | A walk is in progress |
| mem_valid | output | 1 | Read request to table memory |
| mem_addr | output | PA_W | Read address |
| mem_ready | input | 1 | Memory accepts the read; data is valid in the same cycle |
| mem_rdata | input | PA_W+OFF_W+8 | Read data |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 3 | Fault code, 0 when the translation succeeds |
| res_pa | output | PA_W | Physical word address |
| res_seg | output | SEG_W | Segment number of the completed request |
| res_off | output | OFF_W | Offset of the completed request |

## Verification
The assertions watch the read port and the completion protocol on every cycle:
- a read is raised only while busy, and its address stays fixed while the memory stalls;
- `done` never lasts two cycles, and `busy` only falls after `done`;
- idle results do not drift;
- an out-of-range segment retires at once without a read.

The fault codes, their priority, the read addresses and their order, and the assembled physical address depend on table contents. Only the bench's sweep over every segment, offset, kind and ring against a prepared table image can show them.

// File: rtl/pst_pkg.sv
package pst_pkg;

    typedef enum logic [2:0] {
        PST_OK          = 3'd0,
        PST_SEG_RANGE   = 3'd1,
        PST_DSC_ABSENT  = 3'd2,
        PST_SEG_FLAGGED = 3'd3,
        PST_OFF_RANGE   = 3'd4,
        PST_RIGHTS      = 3'd5,
        PST_RING        = 3'd6,
        PST_PAGE_ABSENT = 3'd7
    } pst_fault_e;

    typedef enum logic [2:0] {
        W_IDLE   = 3'd0,
        W_RD_DPT = 3'd1,
        W_RD_SDW = 3'd2,
        W_RD_SPT = 3'd3,
        W_FINISH = 3'd4
    } pst_walk_e;

    localparam logic [1:0] K_READ  = 2'd0;
    localparam logic [1:0] K_WRITE = 2'd1;
    localparam logic [1:0] K_EXEC  = 2'd2;

endpackage

// File: rtl/pst_sdw_check.sv
module pst_sdw_check
    import pst_pkg::*;
#(
    parameter int PA_W  = 24,
    parameter int OFF_W = 14,
    localparam int SDW_W = PA_W + OFF_W + 7
) (
    input  logic [SDW_W-1:0] sdw,
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       kind,
    input  logic [2:0]       ring,
    output pst_fault_e       code,
    output logic [PA_W-1:0]  pt_base
);
    localparam int RING_LO = PA_W + OFF_W;
    localparam int BIT_R   = RING_LO + 3;
    localparam int BIT_W   = RING_LO + 4;
    localparam int BIT_X   = RING_LO + 5;
    localparam int BIT_F   = RING_LO + 6;

    logic [OFF_W-1:0] seg_len;
    logic [2:0]       seg_ring;
    logic             permit;

    assign pt_base  = sdw[PA_W-1:0];
    assign seg_len  = sdw[PA_W +: OFF_W];
    assign seg_ring = sdw[RING_LO +: 3];

    always_comb begin
        unique case (kind)
            K_READ:  permit = sdw[BIT_R];
            K_WRITE: permit = sdw[BIT_W];
            K_EXEC:  permit = sdw[BIT_X];
            default: permit = 1'b0;
        endcase
    end

    always_comb begin
        if (sdw[BIT_F])            code = PST_SEG_FLAGGED;
        else if (off > seg_len)    code = PST_OFF_RANGE;
        else if (ring > seg_ring)  code = PST_RING;
        else if (!permit)          code = PST_RIGHTS;
        else                       code = PST_OK;
    end

endmodule

// File: rtl/pst_addr_mux.sv
module pst_addr_mux
    import pst_pkg::*;
#(
    parameter int PA_W    = 24,
    parameter int PG_BITS = 10,
    parameter int SP_W    = 2,
    parameter int IP_W    = 4,
    localparam int FR_W   = PA_W - PG_BITS
) (
    input  pst_walk_e          state,
    input  logic [PA_W-1:0]    dbr_pt,
    input  logic [SP_W-1:0]    sp,
    input  logic [PG_BITS-1:0] sw,
    input  logic [FR_W-1:0]    dframe,
    input  logic [PA_W-1:0]    spt_base,
    input  logic [IP_W-1:0]    ip,
    output logic [PA_W-1:0]    addr
);
    always_comb begin
        case (state)
            W_RD_DPT: addr = dbr_pt + PA_W'(sp);
            W_RD_SDW: addr = {dframe, sw};
            W_RD_SPT: addr = spt_base + PA_W'(ip);
            default:  addr = '0;
        endcase
    end

endmodule

// File: rtl/pst_translator.sv
module pst_translator
    import pst_pkg::*;
#(
    parameter int PA_W    = 24,
    parameter int SEG_W   = 12,
    parameter int OFF_W   = 14,
    parameter int PG_BITS = 10,
    localparam int DW     = PA_W + OFF_W + 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  dbr_pt,
    input  logic [SEG_W-1:0] dbr_len,
    input  logic             req_valid,
    input  logic [SEG_W-1:0] req_seg,
    input  logic [OFF_W-1:0] req_off,
    input  logic [1:0]       req_kind,
    input  logic [2:0]       req_ring,
    output logic             busy,
    output logic             mem_valid,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_ready,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done,
    output logic [2:0]       res_code,
    output logic [PA_W-1:0]  res_pa,
    output logic [SEG_W-1:0] res_seg,
    output logic [OFF_W-1:0] res_off
);
    localparam int FR_W  = PA_W - PG_BITS;
    localparam int SP_W  = SEG_W - PG_BITS;
    localparam int IP_W  = OFF_W - PG_BITS;
    localparam int SDW_W = DW - 1;

    pst_walk_e        state, state_d;
    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] off_q;
    logic [1:0]       kind_q;
    logic [2:0]       ring_q;
    logic [FR_W-1:0]  dframe_q;
    logic [PA_W-1:0]  spt_q;
    pst_fault_e       code_q;
    logic [PA_W-1:0]  pa_q;

    logic             hs;
    logic             present;
    logic             seg_over;
    pst_fault_e       chk_code;
    logic [PA_W-1:0]  chk_pt;

    assign hs       = mem_valid && mem_ready;
    assign present  = mem_rdata[DW-1];
    assign seg_over = req_seg > dbr_len;

    pst_sdw_check #(.PA_W(PA_W), .OFF_W(OFF_W)) u_check (
        .sdw     (mem_rdata[SDW_W-1:0]),
        .off     (off_q),
        .kind    (kind_q),
        .ring    (ring_q),
        .code    (chk_code),
        .pt_base (chk_pt)
    );

    pst_addr_mux #(.PA_W(PA_W), .PG_BITS(PG_BITS), .SP_W(SP_W), .IP_W(IP_W)) u_addr (
        .state    (state),
        .dbr_pt   (dbr_pt),
        .sp       (seg_q[SEG_W-1:PG_BITS]),
        .sw       (seg_q[PG_BITS-1:0]),
        .dframe   (dframe_q),
        .spt_base (spt_q),
        .ip       (off_q[OFF_W-1:PG_BITS]),
        .addr     (mem_addr)
    );

    // Next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            W_IDLE:   if (req_valid) state_d = seg_over ? W_FINISH : W_RD_DPT;
            W_RD_DPT: if (hs) state_d = present ? W_RD_SDW : W_FINISH;
            W_RD_SDW: if (hs) state_d = (chk_code == PST_OK) ? W_RD_SPT : W_FINISH;
            W_RD_SPT: if (hs) state_d = W_FINISH;
            W_FINISH: state_d = W_IDLE;
            default:  state_d = W_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= W_IDLE;
        else        state <= state_d;
    end

    // Walk data and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q    <= '0;
            off_q    <= '0;
            kind_q   <= '0;
            ring_q   <= '0;
            dframe_q <= '0;
            spt_q    <= '0;
            code_q   <= PST_OK;
            pa_q     <= '0;
        end else begin
            case (state)
                W_IDLE: if (req_valid) begin
                    seg_q  <= req_seg;
                    off_q  <= req_off;
                    kind_q <= req_kind;
                    ring_q <= req_ring;
                    pa_q   <= '0;
                    code_q <= seg_over ? PST_SEG_RANGE : PST_OK;
                end
                W_RD_DPT: if (hs) begin
                    dframe_q <= mem_rdata[FR_W-1:0];
                    if (!present) code_q <= PST_DSC_ABSENT;
                end
                W_RD_SDW: if (hs) begin
                    spt_q  <= chk_pt;
                    code_q <= chk_code;
                end
                W_RD_SPT: if (hs) begin
                    if (present) pa_q <= {mem_rdata[FR_W-1:0], off_q[PG_BITS-1:0]};
                    else         code_q <= PST_PAGE_ABSENT;
                end
                default: ;
            endcase
        end
    end

    assign busy      = (state != W_IDLE);
    assign mem_valid = (state == W_RD_DPT) || (state == W_RD_SDW) || (state == W_RD_SPT);
    assign done      = (state == W_FINISH);
    assign res_code  = code_q;
    assign res_pa    = pa_q;
    assign res_seg   = seg_q;
    assign res_off   = off_q;

endmodule

// File: rtl/pst_translator_chk.sv
module pst_translator_chk #(
    parameter int PA_W  = 24,
    parameter int SEG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEG_W-1:0] dbr_len,
    input logic             req_valid,
    input logic [SEG_W-1:0] req_seg,
    input logic             busy,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [PA_W-1:0]  mem_addr,
    input logic             done,
    input logic [2:0]       res_code,
    input logic [PA_W-1:0]  res_pa
);
    assert_read_when_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);

    assert_read_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_ends_after_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    assert_idle_results_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_valid) |=> ($stable(res_code) && $stable(res_pa)));

    assert_seg_range_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && (req_seg > dbr_len)) |=> (done && !mem_valid && res_code == 3'd1));

endmodule

bind pst_translator pst_translator_chk #(.PA_W(PA_W), .SEG_W(SEG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbr_len   (dbr_len),
    .req_valid (req_valid),
    .req_seg   (req_seg),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .done      (done),
    .res_code  (res_code),
    .res_pa    (res_pa)
);

// File: tb/tb_pst_translator.sv
`timescale 1ns/1ps
module tb_pst_translator;
    localparam int PA_W = 8, SEG_W = 4, OFF_W = 4, PG_BITS = 2;
    localparam int DW = PA_W + OFF_W + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PA_W-1:0] dbr_pt = 8'hF0;
    logic [SEG_W-1:0] dbr_len = 4'd13;
    logic req_valid = 1'b0;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0] req_kind = '0;
    logic [2:0] req_ring = '0;
    logic busy, mem_valid, mem_ready, done;
    logic [PA_W-1:0] mem_addr, res_pa;
    logic [DW-1:0] mem_rdata;
    logic [2:0] res_code;
    logic [SEG_W-1:0] res_seg;
    logic [OFF_W-1:0] res_off;

    logic [DW-1:0] mem [256];
    int log_total = 0;
    logic [PA_W-1:0] log_addr [8];
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    pst_translator #(.PA_W(PA_W), .SEG_W(SEG_W), .OFF_W(OFF_W), .PG_BITS(PG_BITS)) dut (
        .clk(clk), .rst_n(rst_n), .dbr_pt(dbr_pt), .dbr_len(dbr_len),
        .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
        .req_kind(req_kind), .req_ring(req_ring), .busy(busy),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .res_code(res_code),
        .res_pa(res_pa), .res_seg(res_seg), .res_off(res_off)
    );

    assign mem_rdata = mem[mem_addr];

    // Memory model: ready chosen at each falling edge, accepted reads logged.
    always @(negedge clk) begin
        mem_ready = ($urandom % 4) != 0;
        if (mem_valid && mem_ready) begin
            log_addr[log_total % 8] = mem_addr;
            log_total = log_total + 1;
        end
    end

    function automatic string tag_of(input int code);
        case (code)
            0: return "R10";
            1: return "R1";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R7";
            6: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic build_tables();
        for (int a = 0; a < 256; a++) mem[a] = '0;
        for (int k = 0; k < 4; k++)
            mem[240 + k] = DW'(((k != 3 ? 1 : 0) << 19) | (48 + k));
        for (int s = 0; s < 12; s++) begin
            int w;
            w = (s * 4) | ((15 - s) << 8) | ((s & 7) << 12)
              | ((s != 5 ? 1 : 0) << 15) | ((s & 1) << 16)
              | (((s >> 1) & 1) << 17) | ((s == 9 ? 1 : 0) << 18);
            mem[192 + s] = DW'(w);
            for (int ip = 0; ip < 4; ip++)
                mem[s * 4 + ip] = DW'(((((s + ip) % 7) != 3 ? 1 : 0) << 19)
                                      | ((((s * 4 + ip) * 5) + 3) & 63));
        end
    endtask

    task automatic model(input int s, input int i, input int k, input int r, input int dlen,
                         output int code, output int pa, output int nrd, output int a[3]);
        int sp, ip, iw;
        bit ok;
        sp = s >> 2; ip = i >> 2; iw = i & 3; pa = 0;
        a[0] = 240 + sp; a[1] = 192 + s; a[2] = s * 4 + ip;
        ok = (k == 0) ? (s != 5) : (k == 1) ? ((s & 1) == 1) : (k == 2) ? (((s >> 1) & 1) == 1) : 1'b0;
        if (s > dlen) begin code = 1; nrd = 0; end
        else if (sp == 3) begin code = 2; nrd = 1; end
        else begin
            nrd = 2;
            if (s == 9) code = 3;
            else if (i > 15 - s) code = 4;
            else if (r > (s & 7)) code = 6;
            else if (!ok) code = 5;
            else begin
                nrd = 3;
                if (((s + ip) % 7) == 3) code = 7;
                else begin code = 0; pa = ((((s * 4 + ip) * 5) + 3) & 63) * 4 + iw; end
            end
        end
    endtask

    task automatic run_one(input int s, input int i, input int k, input int r);
        int code, pa, nrd, base;
        int a[3];
        string t;
        @(negedge clk);
        while (busy) @(negedge clk);
        base = log_total;
        req_valid = 1'b1; req_seg = SEG_W'(s); req_off = OFF_W'(i);
        req_kind = 2'(k); req_ring = 3'(r);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        model(s, i, k, r, int'(dbr_len), code, pa, nrd, a);
        t = tag_of(code);
        check(t, $sformatf("code s=%0d i=%0d k=%0d r=%0d", s, i, k, r), int'(res_code), code);
        check("R8", $sformatf("reads s=%0d i=%0d", s, i), log_total - base, nrd);
        for (int n = 0; n < 3; n++)
            if (n < nrd && n < log_total - base)
                check("R2", $sformatf("read%0d addr s=%0d i=%0d", n, s, i),
                      int'(log_addr[(base + n) % 8]), a[n]);
        if (code == 0) check("R10", $sformatf("pa s=%0d i=%0d", s, i), int'(res_pa), pa);
        if (code == 7) begin
            check("R9", "echo seg", int'(res_seg), s);
            check("R9", "echo off", int'(res_off), i);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12", "reset done", int'(done), 0);
        check("R12", "reset busy", int'(busy), 0);
        check("R12", "reset mem_valid", int'(mem_valid), 0);
        check("R12", "reset code", int'(res_code), 0);

        // Full sweep with segments 14 and 15 out of range (R1..R10)
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 16; i++)
                for (int k = 0; k < 4; k++)
                    for (int r = 0; r < 8; r++)
                        run_one(s, i, k, r);

        // Widened segment limit: segments 14/15 now reach the absent descriptor page (R3)
        dbr_len = 4'd15;
        for (int s = 0; s < 16; s++)
            for (int i = 0; i < 16; i++)
                run_one(s, i, 0, 0);

        // R12: a request raised while busy is ignored; results then hold
        begin
            int base;
            @(negedge clk);
            while (busy) @(negedge clk);
            base = log_total;
            req_valid = 1'b1; req_seg = 4'd1; req_off = 4'd0; req_kind = 2'd0; req_ring = 3'd0;
            @(negedge clk);
            req_seg = 4'd15; req_off = 4'd7;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            while (!done) @(negedge clk);
            check("R12", "busy-time request ignored: seg", int'(res_seg), 1);
            check("R12", "busy-time request ignored: reads", log_total - base, 3);
            check("R12", "busy-time request ignored: pa", int'(res_pa), ((4 * 5 + 3) & 63) * 4);
            @(negedge clk);
            check("R12", "done one cycle", int'(done), 0);
            repeat (4) @(negedge clk);
            check("R12", "no second walk", int'(busy), 0);
            check("R12", "result held", int'(res_pa), ((4 * 5 + 3) & 63) * 4);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule